// File: doc/BRIEF.md
# Windowed Watchdog Timer Controller

This block is a watchdog timer that software must service on time. It has two byte-wide registers on a simple register bus. The control register selects one of seven time-out rates or turns the watchdog off. It can also enable window mode and make the counter hold while a debug-halt input is active. In normal operating modes the rate and window fields are write-once. In special modes they can be written at any time.

Software services the watchdog by writing 0x55 and then 0xAA to the service register. When window mode is on, these writes are only accepted during the last quarter of the period. A write at the wrong time, a wrong value, a broken sequence or a full-period time-out each raise a reset request that lasts one clock cycle.

The service sequencer is a small state machine:
- `SVC_OFF` is the state while the rate is 000.
- `SVC_IDLE` is the state while a period is running and no 0x55 has been seen.
- `SVC_ARMED` is entered after 0x55 has been accepted.

Its transitions are:
- **enable**: OFF to IDLE, once the rate becomes nonzero.
- **arm**: IDLE to ARMED, when 0x55 is accepted.
- **rearm**: ARMED to ARMED, when a further 0x55 is written.
- **kick**: ARMED to IDLE, when 0xAA is accepted. This restarts the period.
- **fire**: any enabled state to IDLE, with a reset request. This is caused by a time-out, a wrong value, 0xAA with no preceding 0x55, or a write while the window is closed.

Top module: `wdt_ctrl`

## Requirements
- R1: Reading the control register (address 0) returns the following fields: bit 7 window enable, bit 6 debug-freeze enable, bit 2:0 rate. Bits 5:3 read as 0. Reading the service register (address 1) returns 0. After reset the control register reads 0x00 with the default parameters.
- R2: In normal mode (`special_mode`=0), the rate and window fields accept only the first unmasked control write after reset. A write of rate 000 or window 0 changes nothing in that field, but it still uses up the single permitted write.
- R3: A control write with bit 5 (write-mask) set leaves the rate and window fields unchanged. It does not use up the write-once permission and does not restart the period.
- R4: In special mode, the rate and window fields can be written any number of times. Rate 000 and window 0 still have no effect. The freeze bit takes the written value, so it can be cleared.
- R5: In normal mode, the freeze bit can be set but not cleared.
- R6: Rate code n (1 to 7) gives a period of 2^(2n+BASE_LOG2) cycles. `rst_req` goes high for exactly one cycle, `period` cycles after the last restart, unless the watchdog is serviced. Writing an accepted nonzero rate with the write-mask bit clear restarts the period.
- R7: A change of the freeze bit from 0 to 1 restarts the period.
- R8: Writing 0x55 and then 0xAA to the service register restarts the period. 0x55 may be repeated any number of times before the 0xAA.
- R9: While the watchdog is enabled, any of the following raises `rst_req` in the next cycle: a service write of any value other than 0x55 or 0xAA, or a write of 0xAA that is not preceded by 0x55.
- R10: With window mode on, a service write raises `rst_req` if the count is below 3/4 of the period, and is accepted from that count on. After an accepted 0xAA the window is closed again.
- R11: While the freeze bit is 1 and `debug_active` is high, the count holds. While the freeze bit is 0, the count keeps running in debug.
- R12: While the rate is 000, the counter is stopped, service writes are ignored and `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode (registers freely writable) |
| debug_active | input | 1 | Debug halt is active |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = service register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register selected by `bus_addr` |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The control-register rules are driven from a table of write values with their expected read-back. The table covers:
- masked writes;
- no-effect writes that still lock the register;
- attempts to clear the freeze bit;
- the same writes in special mode.

These writes separate a register that locks correctly from one that locks too early, locks too late, or never locks. The time-out path is measured by counting cycles to the reset request from several restart sources: a rate write, a freeze-bit rising edge, a masked write that must not restart, and a completed 0x55/0xAA service. The window is probed one count below and exactly at its three-quarter threshold, which exposes off-by-one window decoding.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SVC_OFF   = 2'd0,
        SVC_IDLE  = 2'd1,
        SVC_ARMED = 2'd2
    } svc_state_e;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_KICK = 8'hAA;

    localparam int BIT_WIN  = 7;
    localparam int BIT_FRZ  = 6;
    localparam int BIT_MASK = 5;

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
    import wdt_pkg::*;
#(
    parameter logic       RST_WIN  = 1'b0,
    parameter logic [2:0] RST_RATE = 3'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic       win,
    output logic       frz,
    output logic [2:0] rate,
    output logic       locked,
    output logic       restart,
    output logic [7:0] rdata
);

    logic       allowed;
    logic       field_wr;
    logic       rate_ld;
    logic       win_set;
    logic       frz_next;
    logic       frz_rise;
    logic       unused_bits;

    assign unused_bits = ^wdata[4:3];

    always_comb begin
        allowed  = special_mode | ~locked;
        field_wr = wr_en & allowed & ~wdata[BIT_MASK];
        rate_ld  = field_wr & (wdata[2:0] != 3'd0);
        win_set  = field_wr & wdata[BIT_WIN];
        frz_next = special_mode ? wdata[BIT_FRZ] : (frz | wdata[BIT_FRZ]);
        frz_rise = wr_en & ~frz & frz_next;
        restart  = rate_ld | frz_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win    <= RST_WIN;
            frz    <= 1'b0;
            rate   <= RST_RATE;
            locked <= 1'b0;
        end else begin
            if (rate_ld) begin
                rate <= wdata[2:0];
            end
            if (win_set) begin
                win <= 1'b1;
            end
            if (wr_en) begin
                frz <= frz_next;
            end
            if (field_wr && !special_mode) begin
                locked <= 1'b1;
            end
        end
    end

    assign rdata = {win, frz, 3'b000, rate};

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int BASE_LOG2 = 8,
    parameter int CW        = BASE_LOG2 + 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate,
    input  logic       hold,
    input  logic       restart,
    output logic       win_open,
    output logic       expire
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW-1:0] win_start;
    logic          running;
    int            shamt;

    always_comb begin
        shamt     = BASE_LOG2 + 2 * int'(rate);
        limit     = (CW'(1) << shamt) - CW'(1);
        win_start = CW'(3) << (shamt - 2);
        running   = (rate != 3'd0) && !hold;
        expire    = running && (cnt == limit);
        win_open  = (cnt >= win_start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_svc_fsm.sv
module wdt_svc_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enabled,
    input  logic       win_mode,
    input  logic       win_open,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       expire,
    output logic       rst_req,
    output logic       restart
);

    svc_state_e state;
    svc_state_e state_n;
    logic       fire;
    logic       kick;
    logic       too_early;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SVC_OFF;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n   = state;
        fire      = 1'b0;
        kick      = 1'b0;
        too_early = win_mode && !win_open;
        if (!enabled) begin
            state_n = SVC_OFF;
        end else begin
            unique case (state)
                SVC_OFF, SVC_IDLE: begin
                    state_n = SVC_IDLE;
                    if (expire) begin
                        fire = 1'b1;
                    end else if (wr_en) begin
                        if (too_early || wdata != KEY_ARM) begin
                            fire = 1'b1;
                        end else begin
                            state_n = SVC_ARMED;
                        end
                    end
                end
                SVC_ARMED: begin
                    if (expire) begin
                        fire = 1'b1;
                    end else if (wr_en) begin
                        if (too_early) begin
                            fire = 1'b1;
                        end else if (wdata == KEY_ARM) begin
                            state_n = SVC_ARMED;
                        end else if (wdata == KEY_KICK) begin
                            kick    = 1'b1;
                            state_n = SVC_IDLE;
                        end else begin
                            fire = 1'b1;
                        end
                    end
                end
                default: state_n = SVC_OFF;
            endcase
            if (fire) begin
                state_n = SVC_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
        end
    end

    assign restart = fire | kick;

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
    parameter int         BASE_LOG2 = 8,
    parameter logic       RST_WIN   = 1'b0,
    parameter logic [2:0] RST_RATE  = 3'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       debug_active,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       rst_req
);

    localparam int CNT_W = BASE_LOG2 + 14;

    logic       ctl_win;
    logic       ctl_frz;
    logic [2:0] ctl_rate;
    logic       ctl_locked;
    logic       ctl_restart;
    logic [7:0] ctl_rdata;
    logic       svc_restart;
    logic       win_open;
    logic       expire;
    logic       cnt_hold;
    logic       cnt_restart;
    logic       enabled;

    assign enabled     = (ctl_rate != 3'd0);
    assign cnt_hold    = ctl_frz & debug_active;
    assign cnt_restart = ctl_restart | svc_restart;

    wdt_ctl_reg #(
        .RST_WIN  (RST_WIN),
        .RST_RATE (RST_RATE)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wr_en        (bus_wr & ~bus_addr),
        .wdata        (bus_wdata),
        .win          (ctl_win),
        .frz          (ctl_frz),
        .rate         (ctl_rate),
        .locked       (ctl_locked),
        .restart      (ctl_restart),
        .rdata        (ctl_rdata)
    );

    wdt_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .CW        (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (ctl_rate),
        .hold     (cnt_hold),
        .restart  (cnt_restart),
        .win_open (win_open),
        .expire   (expire)
    );

    wdt_svc_fsm u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .enabled  (enabled),
        .win_mode (ctl_win),
        .win_open (win_open),
        .wr_en    (bus_wr & bus_addr),
        .wdata    (bus_wdata),
        .expire   (expire),
        .rst_req  (rst_req),
        .restart  (svc_restart)
    );

    assign bus_rdata = bus_addr ? 8'h00 : ctl_rdata;

endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       special_mode,
    input logic       debug_active,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic       ctl_win,
    input logic       ctl_frz,
    input logic [2:0] ctl_rate,
    input logic       ctl_locked,
    input logic       win_open,
    input logic       expire,
    input logic       rst_req
);

    p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_locked) && !special_mode && $past(!special_mode))
        |-> ($stable(ctl_rate) && $stable(ctl_win)));

    p_frz_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_frz) && !special_mode && $past(!special_mode)) |-> ctl_frz);

    p_expire_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> rst_req);

    p_early_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_win && ctl_rate != 3'd0 && bus_wr && bus_addr && !win_open) |=> rst_req);

    p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_frz && debug_active) |-> !expire);

    p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rate == 3'd0 && $past(ctl_rate == 3'd0)) |-> !rst_req);

endmodule

bind wdt_ctrl wdt_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .debug_active (debug_active),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .ctl_win      (ctl_win),
    .ctl_frz      (ctl_frz),
    .ctl_rate     (ctl_rate),
    .ctl_locked   (ctl_locked),
    .win_open     (win_open),
    .expire       (expire),
    .rst_req      (rst_req)
);

// File: tb/wdt_ctrl_bench.sv
`timescale 1ns/1ps
module wdt_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       debug_active = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    wdt_ctrl #(.BASE_LOG2(2)) u_wdt_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .debug_active (debug_active),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rst_req      (rst_req)
    );

    // {reset first, special mode, control write value, expected read-back}
    localparam logic [17:0] VEC [0:9] = '{
        {1'b1, 1'b0, 8'h00, 8'h00},   // R2 no-effect write consumes the lock
        {1'b0, 1'b0, 8'h83, 8'h00},   // R2 later write ignored
        {1'b1, 1'b0, 8'h22, 8'h00},   // R3 masked write ignored
        {1'b0, 1'b0, 8'h82, 8'h82},   // R3 mask did not consume the lock
        {1'b0, 1'b0, 8'h41, 8'hC2},   // R5 freeze set after lock, rate held
        {1'b0, 1'b0, 8'h03, 8'hC2},   // R5 freeze not cleared
        {1'b1, 1'b1, 8'h43, 8'h43},   // R4 special write
        {1'b0, 1'b1, 8'h05, 8'h05},   // R4 rewrite, freeze cleared
        {1'b0, 1'b1, 8'h80, 8'h85},   // R4 rate 000 no effect, window set
        {1'b0, 1'b1, 8'h26, 8'h85}    // R3 masked in special mode
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        bus_wr = 1'b0;
        debug_active = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic addr, input logic [7:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
        bus_addr  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cycles_to_req(output int k);
        k = 0;
        do begin
            tick();
            k++;
        end while (!rst_req && k < 400);
    endtask

    initial begin
        int k;
        int seen;
        logic [17:0] v;

        do_reset();
        bus_addr = 1'b0;
        chk("R1 reset control read", bus_rdata, 8'h00);
        chk("R1 reset rst_req", rst_req, 0);

        for (int i = 0; i < 10; i++) begin
            v = VEC[i];
            if (v[17]) begin
                special_mode = 1'b0;
                do_reset();
            end
            special_mode = v[16];
            wr(1'b0, v[15:8]);
            bus_addr = 1'b0;
            chk($sformatf("R1/R2-R5 table row %0d", i), bus_rdata, v[7:0]);
        end
        special_mode = 1'b0;

        // R12 disabled watchdog
        do_reset();
        wr(1'b1, 8'h12);
        chk("R12 bad write ignored when off", rst_req, 0);
        bus_addr = 1'b1;
        chk("R1 service register reads 0", bus_rdata, 0);
        bus_addr = 1'b0;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (rst_req) seen = 1;
        end
        chk("R12 no time-out when off", seen, 0);

        // R6 time-out periods and single-cycle pulse
        do_reset();
        wr(1'b0, 8'h01);
        cycles_to_req(k);
        chk("R6 rate1 period", k, 16);
        tick();
        chk("R6 pulse one cycle", rst_req, 0);
        cycles_to_req(k);
        chk("R6 period after auto restart", k, 15);
        do_reset();
        wr(1'b0, 8'h03);
        cycles_to_req(k);
        chk("R6 rate3 period", k, 256);

        // R6 special-mode rate write restarts
        do_reset();
        special_mode = 1'b1;
        wr(1'b0, 8'h01);
        idle(9);
        wr(1'b0, 8'h02);
        cycles_to_req(k);
        chk("R6 rate write restarts period", k, 64);

        // R3 masked write does not restart
        do_reset();
        wr(1'b0, 8'h01);
        idle(9);
        wr(1'b0, 8'h21);
        cycles_to_req(k);
        chk("R3 masked write no restart", k, 6);
        special_mode = 1'b0;

        // R7 freeze rising edge restarts
        do_reset();
        wr(1'b0, 8'h01);
        idle(9);
        wr(1'b0, 8'h40);
        cycles_to_req(k);
        chk("R7 freeze set restarts period", k, 16);

        // R11 counter holds in debug with freeze on
        do_reset();
        wr(1'b0, 8'h41);
        debug_active = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (rst_req) seen = 1;
        end
        chk("R11 no time-out while frozen", seen, 0);
        debug_active = 1'b0;
        cycles_to_req(k);
        chk("R11 count resumes from hold", k, 16);
        do_reset();
        wr(1'b0, 8'h01);
        debug_active = 1'b1;
        cycles_to_req(k);
        chk("R11 runs in debug without freeze", k, 16);
        debug_active = 1'b0;

        // R8 service sequence in normal mode
        do_reset();
        wr(1'b0, 8'h01);
        idle(5);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h55);
        chk("R8 repeated 0x55 accepted", rst_req, 0);
        wr(1'b1, 8'hAA);
        chk("R8 0xAA after 0x55 accepted", rst_req, 0);
        cycles_to_req(k);
        chk("R8 service restarts period", k, 16);

        // R9 sequence errors
        do_reset();
        wr(1'b0, 8'h01);
        idle(2);
        wr(1'b1, 8'hAA);
        chk("R9 0xAA without 0x55", rst_req, 1);
        tick();
        chk("R9 request lasts one cycle", rst_req, 0);
        wr(1'b1, 8'h12);
        chk("R9 wrong service value", rst_req, 1);

        // R10 window mode, rate 2: period 64, window from count 48
        do_reset();
        wr(1'b0, 8'h82);
        idle(10);
        wr(1'b1, 8'h55);
        chk("R10 early write resets", rst_req, 1);
        do_reset();
        wr(1'b0, 8'h82);
        idle(47);
        wr(1'b1, 8'h55);
        chk("R10 write at count 47 resets", rst_req, 1);
        do_reset();
        wr(1'b0, 8'h82);
        idle(48);
        wr(1'b1, 8'h55);
        chk("R10 write at count 48 accepted", rst_req, 0);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'hAA);
        chk("R10 kick inside window", rst_req, 0);
        wr(1'b1, 8'h55);
        chk("R10 window closed after kick", rst_req, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(3_000_000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule